// File: doc/BRIEF.md
# Return-from-Interrupt State Restore

This block works out the machine-state word and the next fetch address at the moment an interrupt handler returns. It reads three 64-bit words: the current state word, the saved return address, and the saved state word. From these it produces the restored state word and the address where execution resumes. Each output has a valid flag.

Most of the restored state comes straight from the saved word, but not all of it:

- The machine-check enable bit and the three-bit transaction-state field are restored only when conditions on the current state allow it.
- When the saved problem-state (user mode) bit is set, the external-interrupt enable and both address-translation enables are forced on.
- The hypervisor bit is held at its current value.
- Reserved positions read as zero.

The logic is purely combinational. The caller raises the request input during the cycle of the return operation and takes both results in that same cycle. All bit numbers in this document count from the most significant end: bit 0 is vector index 63 and bit n is index 63-n.

Top module: `rfi_state_restore`

## Requirements
- R1: While req_i is high, new_state_o bit 51 (index 12) equals save_state_i bit 51 when cur_state_i bit 3 (index 60) is 1. Otherwise it equals cur_state_i bit 51.
- R2: While req_i is high, new_state_o bits 29..31 (indices 34..32) are set as follows. If cur_state_i bits 29..31 are 3'b010 and save_state_i bits 29..31 are 3'b000, the field keeps the cur_state_i value. In every other case it takes the save_state_i value.
- R3: While req_i is high, new_state_o bits 48, 58 and 59 (indices 15, 5, 4) each equal the same save_state_i bit ORed with save_state_i bit 49 (index 14).
- R4: While req_i is high, new_state_o bits 0..2, 4..28, 32, 37..41, 49..50, 52..57 and 60..63 equal the same bits of save_state_i.
- R5: While req_i is high, new_state_o bit 3 (index 60) equals cur_state_i bit 3.
- R6: While req_i is high, new_state_o bits 33..36 and 42..47 are zero.
- R7: While req_i is high, next_pc_o equals save_addr_i with its two least significant bits (indices 1..0) forced to zero.
- R8: While req_i is high, both state_vld_o and pc_vld_o are 1.
- R9: While req_i is low, state_vld_o and pc_vld_o are 0, and new_state_o and next_pc_o are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 1 | Return operation present this cycle |
| cur_state_i | input | 64 | Current machine-state word |
| save_addr_i | input | 64 | Saved return address |
| save_state_i | input | 64 | Saved machine-state word |
| new_state_o | output | 64 | Restored machine-state word |
| state_vld_o | output | 1 | new_state_o is valid |
| next_pc_o | output | 64 | Address where execution resumes |
| pc_vld_o | output | 1 | next_pc_o is valid |

## Verification
Two rules can act on the same output word in one operation.

- The first is the problem-state override on the enable bits.
- The second is the conditional restores: the hypervisor-gated machine-check bit and the guarded transaction-state field.

The bench builds words where the saved problem-state bit is set and the enable bits are clear. In those same words it sets the current transaction field to 3'b010 and the saved field to 3'b000, and it toggles the hypervisor bit. Every bit of each result is compared against a behavioural model. Any mismatch is reported against the requirement that owns that bit position, so a fault in one rule cannot be hidden by the other.

// File: rtl/rfi_state_restore.sv
module rfi_state_restore (
  input  logic        req_i,
  input  logic [63:0] cur_state_i,
  input  logic [63:0] save_addr_i,
  input  logic [63:0] save_state_i,
  output logic [63:0] new_state_o,
  output logic        state_vld_o,
  output logic [63:0] next_pc_o,
  output logic        pc_vld_o
);
  localparam int W        = 64;
  localparam int HYP      = W - 1 - 3;
  localparam int MCHK     = W - 1 - 51;
  localparam int USER     = W - 1 - 49;
  localparam int EXT_EN   = W - 1 - 48;
  localparam int ITR_EN   = W - 1 - 58;
  localparam int DTR_EN   = W - 1 - 59;
  localparam int TS_HI    = W - 1 - 29;
  localparam int TS_LO    = W - 1 - 31;
  localparam int RSA_HI   = W - 1 - 33;
  localparam int RSA_LO   = W - 1 - 36;
  localparam int RSB_HI   = W - 1 - 42;
  localparam int RSB_LO   = W - 1 - 47;

  logic        user_mode;
  logic        hold_ts;
  logic [63:0] restored;

  assign user_mode = save_state_i[USER];
  assign hold_ts   = (cur_state_i[TS_HI:TS_LO] == 3'b010) &&
                     (save_state_i[TS_HI:TS_LO] == 3'b000);

  always_comb begin
    restored                = save_state_i;
    restored[HYP]           = cur_state_i[HYP];
    restored[MCHK]          = cur_state_i[HYP] ? save_state_i[MCHK] : cur_state_i[MCHK];
    restored[TS_HI:TS_LO]   = hold_ts ? cur_state_i[TS_HI:TS_LO] : save_state_i[TS_HI:TS_LO];
    restored[RSA_HI:RSA_LO] = '0;
    restored[RSB_HI:RSB_LO] = '0;
    restored[EXT_EN]        = save_state_i[EXT_EN] | user_mode;
    restored[ITR_EN]        = save_state_i[ITR_EN] | user_mode;
    restored[DTR_EN]        = save_state_i[DTR_EN] | user_mode;
  end

  assign new_state_o = req_i ? restored : '0;
  assign next_pc_o   = req_i ? {save_addr_i[63:2], 2'b00} : '0;
  assign state_vld_o = req_i;
  assign pc_vld_o    = req_i;
endmodule

// File: rtl/rfi_state_restore_chk.sv
module rfi_state_restore_chk (
  input logic        req_i,
  input logic [63:0] cur_state_i,
  input logic [63:0] save_addr_i,
  input logic [63:0] save_state_i,
  input logic [63:0] new_state_o,
  input logic        state_vld_o,
  input logic [63:0] next_pc_o,
  input logic        pc_vld_o
);
  always_comb begin
    if (req_i) begin
      p_mchk_gate_r1: assert (new_state_o[12] == (cur_state_i[60] ? save_state_i[12] : cur_state_i[12]))
        else $error("mchk gate");
      p_ts_guard_r2: assert ((cur_state_i[34:32] == 3'b010 && save_state_i[34:32] == 3'b000)
                             ? new_state_o[34:32] == cur_state_i[34:32]
                             : new_state_o[34:32] == save_state_i[34:32])
        else $error("ts guard");
      p_user_force_r3: assert (!save_state_i[14] || (new_state_o[15] && new_state_o[5] && new_state_o[4]))
        else $error("user force");
      p_copy_low_r4: assert (new_state_o[63:61] == save_state_i[63:61] && new_state_o[3:0] == save_state_i[3:0])
        else $error("copy");
      p_hyp_hold_r5: assert (new_state_o[60] == cur_state_i[60])
        else $error("hyp hold");
      p_rsvd_zero_r6: assert (new_state_o[30:27] == 4'd0 && new_state_o[21:16] == 6'd0)
        else $error("rsvd");
      p_pc_align_r7: assert (next_pc_o[1:0] == 2'b00 && next_pc_o[63:2] == save_addr_i[63:2])
        else $error("pc");
      p_vld_r8: assert (state_vld_o && pc_vld_o)
        else $error("vld");
    end else begin
      p_idle_r9: assert (!state_vld_o && !pc_vld_o && new_state_o == '0 && next_pc_o == '0)
        else $error("idle");
    end
  end
endmodule

bind rfi_state_restore rfi_state_restore_chk u_chk (
  .req_i(req_i), .cur_state_i(cur_state_i), .save_addr_i(save_addr_i),
  .save_state_i(save_state_i), .new_state_o(new_state_o), .state_vld_o(state_vld_o),
  .next_pc_o(next_pc_o), .pc_vld_o(pc_vld_o)
);

// File: tb/rfi_state_restore_test.sv
module rfi_state_restore_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [63:0] cur_state_i = '0;
  logic [63:0] save_addr_i = '0;
  logic [63:0] save_state_i = '0;
  logic [63:0] new_state_o;
  logic        state_vld_o;
  logic [63:0] next_pc_o;
  logic        pc_vld_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rfi_state_restore uut (
    .req_i(req_i), .cur_state_i(cur_state_i), .save_addr_i(save_addr_i),
    .save_state_i(save_state_i), .new_state_o(new_state_o), .state_vld_o(state_vld_o),
    .next_pc_o(next_pc_o), .pc_vld_o(pc_vld_o)
  );

  function automatic bit gb(logic [63:0] w, int n);
    return w[63 - n];
  endfunction

  function automatic int owner(int n);
    if (n == 51) return 1;
    if (n >= 29 && n <= 31) return 2;
    if (n == 48 || n == 58 || n == 59) return 3;
    if (n == 3) return 5;
    if ((n >= 33 && n <= 36) || (n >= 42 && n <= 47)) return 6;
    return 4;
  endfunction

  function automatic bit model_bit(logic [63:0] c, logic [63:0] s, int n);
    int r = owner(n);
    bit hold = (gb(c,29) == 0 && gb(c,30) == 1 && gb(c,31) == 0) &&
               (gb(s,29) == 0 && gb(s,30) == 0 && gb(s,31) == 0);
    case (r)
      1: return gb(c,3) ? gb(s,n) : gb(c,n);
      2: return hold ? gb(c,n) : gb(s,n);
      3: return gb(s,n) | gb(s,49);
      5: return gb(c,n);
      6: return 1'b0;
      default: return gb(s,n);
    endcase
  endfunction

  task automatic compare();
    int bad [1:9];
    for (int r = 1; r <= 9; r++) bad[r] = 0;
    if (req_i) begin
      for (int n = 0; n < 64; n++)
        if (gb(new_state_o, n) !== model_bit(cur_state_i, save_state_i, n)) begin
          bad[owner(n)]++;
          $display("FAIL R%0d state bit %0d actual %0b expected %0b", owner(n), n,
                   gb(new_state_o, n), model_bit(cur_state_i, save_state_i, n));
        end
      for (int r = 1; r <= 6; r++) if (r != 0) checks++;
      checks++;
      if (next_pc_o !== (save_addr_i & ~64'h3)) begin
        bad[7]++;
        $display("FAIL R7 next pc actual %h expected %h", next_pc_o, save_addr_i & ~64'h3);
      end
      checks++;
      if (state_vld_o !== 1'b1 || pc_vld_o !== 1'b1) begin
        bad[8]++;
        $display("FAIL R8 valid flags actual %b%b expected 11", state_vld_o, pc_vld_o);
      end
    end else begin
      checks++;
      if (state_vld_o !== 1'b0 || pc_vld_o !== 1'b0 || new_state_o !== '0 || next_pc_o !== '0) begin
        bad[9]++;
        $display("FAIL R9 idle actual %b%b %h %h expected 00 0 0", state_vld_o, pc_vld_o,
                 new_state_o, next_pc_o);
      end
    end
    for (int r = 1; r <= 9; r++) if (bad[r] != 0) errors++;
  endtask

  always @(negedge clk) if (!done) begin
    cycles++;
    compare();
    if (cycles > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected <5000", cycles);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(bit r, logic [63:0] c, logic [63:0] a, logic [63:0] s);
    @(posedge clk);
    #1;
    req_i = r; cur_state_i = c; save_addr_i = a; save_state_i = s;
  endtask

  function automatic logic [63:0] setb(logic [63:0] w, int n, bit v);
    logic [63:0] t = w;
    t[63 - n] = v;
    return t;
  endfunction

  function automatic logic [63:0] ts(logic [63:0] w, logic [2:0] v);
    logic [63:0] t = w;
    t[34:32] = v;
    return t;
  endfunction

  initial begin
    logic [63:0] c, s;
    repeat (3) @(posedge clk);
    rst = 0;
    // R9: idle with busy inputs
    drive(0, '1, '1, '1);
    // R7 R8 R4: straight pattern
    drive(1, 64'h0, 64'h1234_5678_9abc_def3, 64'hA5A5_A5A5_A5A5_A5A5);
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 64'h5A5A_5A5A_5A5A_5A5A);
    // R1: hypervisor bit set and clear
    c = setb(64'h0, 3, 1); s = setb(64'h0, 51, 1);
    drive(1, c, 64'h100, s);
    c = setb(64'h0, 51, 1); s = 64'h0;
    drive(1, c, 64'h101, s);
    drive(1, setb(c, 3, 1), 64'h103, s);
    // R2: guarded transaction field
    drive(1, ts(64'h0, 3'b010), 64'h8, ts(64'h0, 3'b000));
    drive(1, ts(64'h0, 3'b010), 64'h8, ts(64'h0, 3'b001));
    drive(1, ts(64'h0, 3'b011), 64'h8, ts(64'h0, 3'b000));
    drive(1, ts(64'h0, 3'b110), 64'h8, ts(64'h0, 3'b101));
    // R3: user bit forces enables; R5 hypervisor held
    s = setb(64'h0, 49, 1);
    drive(1, 64'h0, 64'hC, s);
    drive(1, setb(64'h0, 3, 1), 64'hD, setb(64'h0, 3, 0));
    drive(1, 64'h0, 64'hE, setb(64'h0, 3, 1));
    // R6: reserved zero with all-ones save
    drive(1, 64'h0, 64'hF, '1);
    // combined: user override with guarded field and hyp toggle
    for (int h = 0; h < 2; h++) begin
      c = ts(setb(64'h0, 3, h[0]), 3'b010);
      s = setb(ts(64'h0, 3'b000), 49, 1);
      s = setb(s, 51, 1);
      drive(1, c, 64'hFFFF_FFFF_FFFF_FFFF, s);
    end
    drive(0, 64'h1, 64'h2, 64'h3);
    for (int i = 0; i < 200; i++)
      drive(($urandom % 5) != 0, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    drive(0, '0, '0, '0);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule